// File: doc/BRIEF.md
# Per-Cycle Load/Store Cache Port Limiter

This block limits how many cache requests a load/store unit may send in one clock cycle. Loads and stores each have their own per-cycle budget, set by a parameter. Every cycle, the block looks at a vector of load requesters and a vector of store requesters. It grants requests in fixed priority order, lowest index first, until the budget of that kind runs out. Requests left over are refused for that cycle, and the requester tries again later.

Issued requests go to the data cache. The cache answers in the same cycle, either by accepting everything issued or by rejecting it with `cache_nack`. A port is used up only when the cache accepts. A rejection marks the cache as blocked, and while the cache is blocked nothing is issued. The blocked mark stays until the cache raises `cache_ready`.

The block has three more outputs:
- A one-cycle wake-up, raised after a cycle in which the load budget was used up exactly, so that loads stalled by the limit can retry.
- A store-ordering gate. When total store ordering is enabled, only one store may be outstanding at a time.
- A store-blocked flag, which reports that the most recent store issue was rejected.

Top module: `ls_port_limiter`

## Requirements
- R1: In a cycle where the cache is not blocked, load requesters are granted in ascending index order. A load is granted only if its `ld_req` bit is 1. At most `LD_LIMIT` loads are granted, and any further load requests are refused for that cycle.
- R2: In a cycle where the cache is not blocked and store ordering does not restrict it, store requesters are granted in ascending index order. A store is granted only if its `st_req` bit is 1. At most `ST_LIMIT` stores are granted.
- R3: While `cache_blocked` is 1, no load or store is issued. `cache_blocked` becomes 1 after the clock edge that ends a cycle in which at least one request was issued and `cache_nack` was 1. It returns to 0 after the edge that ends a cycle with `cache_ready` at 1 and no new rejection.
- R4: A cycle whose issued requests are rejected uses up no port. A rejected cycle therefore never causes `ld_wake`, even if it issued `LD_LIMIT` loads.
- R5: `ld_wake` is 1 for the cycle that follows a cycle in which exactly `LD_LIMIT` loads were issued and accepted. Otherwise it is 0.
- R6: The load and store budgets are independent. Using up one budget does not reduce the grants of the other kind in the same cycle.
- R7: With `tso_en` at 1, at most one store is issued per cycle, and none is issued while `st_busy` is 1. `st_busy` becomes 1 after a cycle in which a store was accepted. It becomes 0 after a cycle with `st_done` at 1 and no newly accepted store.
- R8: With `tso_en` at 0, `st_busy` has no effect on store grants.
- R9: `st_blocked` becomes 1 after a cycle in which a store was issued and rejected. It becomes 0 after a cycle in which a store was issued and accepted.
- R10: Synchronous active-high reset sets `ld_wake`, `cache_blocked`, `st_blocked` and `st_busy` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tso_en | input | 1 | Enables the total-store-ordering gate on stores |
| ld_req | input | NUM_LD | Load requesters asking for a port this cycle |
| st_req | input | NUM_ST | Store requesters (head store valid and ready) asking for a port |
| cache_nack | input | 1 | The cache rejects the requests issued this cycle |
| cache_ready | input | 1 | The cache can accept requests again |
| st_done | input | 1 | The outstanding store has completed |
| ld_issue | output | NUM_LD | Loads sent to the cache this cycle |
| st_issue | output | NUM_ST | Stores sent to the cache this cycle |
| ld_wake | output | 1 | One-cycle pulse: the load budget was used up in the previous cycle |
| cache_blocked | output | 1 | The cache is marked blocked |
| st_blocked | output | 1 | The last store issue was rejected |
| st_busy | output | 1 | An accepted store is still outstanding |

## Verification
The assertions check these properties on every cycle:
- Grants never exceed the budget and never go to a requester that is not asking.
- Nothing is issued while the cache is blocked.
- A rejected issue always leads to the blocked state.
- Under ordering, there is a single store grant and it is held off while a store is outstanding.
- Every wake pulse follows an accepted cycle that used the full load budget.

Some behaviours appear only in the bench scenarios:
- The exact priority pattern for each mix of requests.
- The absence of a wake after a rejected full-budget cycle.
- The way `cache_ready` clears the blocked state.
- The return of store grants once `st_busy` clears or ordering is turned off.

// File: rtl/ls_port_limiter.sv
module ls_port_limiter #(
  parameter int NUM_LD   = 4,
  parameter int NUM_ST   = 4,
  parameter int LD_LIMIT = 200,
  parameter int ST_LIMIT = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tso_en,
  input  logic [NUM_LD-1:0] ld_req,
  input  logic [NUM_ST-1:0] st_req,
  input  logic              cache_nack,
  input  logic              cache_ready,
  input  logic              st_done,
  output logic [NUM_LD-1:0] ld_issue,
  output logic [NUM_ST-1:0] st_issue,
  output logic              ld_wake,
  output logic              cache_blocked,
  output logic              st_blocked,
  output logic              st_busy
);
  localparam int LCW = $clog2(LD_LIMIT + 1);
  localparam int SCW = $clog2(ST_LIMIT + 1);
  localparam logic [LCW-1:0] LD_MAX = LCW'(LD_LIMIT);
  localparam logic [SCW-1:0] ST_MAX = SCW'(ST_LIMIT);

  logic [LCW-1:0] ld_cnt, ld_used;
  logic [SCW-1:0] st_cnt, st_cap;
  logic           st_open, any_issue, st_any, st_acc, blk_d;

  assign st_cap  = tso_en ? SCW'(1) : ST_MAX;
  assign st_open = !cache_blocked && !(tso_en && st_busy);

  always_comb begin
    ld_cnt   = '0;
    ld_issue = '0;
    for (int i = 0; i < NUM_LD; i++) begin
      if (ld_req[i] && !cache_blocked && ld_cnt < LD_MAX) begin
        ld_issue[i] = 1'b1;
        ld_cnt      = ld_cnt + LCW'(1);
      end
    end
  end

  always_comb begin
    st_cnt   = '0;
    st_issue = '0;
    for (int j = 0; j < NUM_ST; j++) begin
      if (st_req[j] && st_open && st_cnt < st_cap) begin
        st_issue[j] = 1'b1;
        st_cnt      = st_cnt + SCW'(1);
      end
    end
  end

  assign st_any    = |st_issue;
  assign any_issue = (|ld_issue) || st_any;
  assign st_acc    = st_any && !cache_nack;
  assign ld_used   = cache_nack ? '0 : ld_cnt;
  assign blk_d     = (any_issue && cache_nack) ? 1'b1 :
                     (cache_ready ? 1'b0 : cache_blocked);

  always_ff @(posedge clk) begin
    if (rst) begin
      ld_wake       <= 1'b0;
      cache_blocked <= 1'b0;
      st_blocked    <= 1'b0;
      st_busy       <= 1'b0;
    end else begin
      ld_wake       <= (ld_used == LD_MAX) && !blk_d;
      cache_blocked <= blk_d;
      if (st_any) st_blocked <= cache_nack;
      if (st_acc) st_busy <= 1'b1;
      else if (st_done) st_busy <= 1'b0;
    end
  end

  a_r1_ld_budget: assert property (@(posedge clk) disable iff (rst)
    $countones(ld_issue) <= LD_LIMIT);
  a_r1_ld_only_req: assert property (@(posedge clk) disable iff (rst)
    (ld_issue & ~ld_req) == '0);
  a_r2_st_budget: assert property (@(posedge clk) disable iff (rst)
    $countones(st_issue) <= ST_LIMIT);
  a_r3_quiet_blocked: assert property (@(posedge clk) disable iff (rst)
    cache_blocked |-> (ld_issue == '0 && st_issue == '0));
  a_r3_nack_blocks: assert property (@(posedge clk) disable iff (rst)
    (cache_nack && ((|ld_issue) || (|st_issue))) |=> cache_blocked);
  a_r5_wake_cause: assert property (@(posedge clk) disable iff (rst)
    ld_wake |-> $past(!cache_nack && $countones(ld_issue) == LD_LIMIT));
  a_r7_tso_single: assert property (@(posedge clk) disable iff (rst)
    tso_en |-> $countones(st_issue) <= 1);
  a_r7_tso_busy: assert property (@(posedge clk) disable iff (rst)
    (tso_en && st_busy) |-> st_issue == '0);
  a_r9_st_accept_clears: assert property (@(posedge clk) disable iff (rst)
    ((|st_issue) && !cache_nack) |=> !st_blocked);
endmodule

// File: tb/ls_port_limiter_bench.sv
module ls_port_limiter_bench;
  localparam int CLK_P = 10;
  localparam int NL = 4, NS = 4;

  logic clk = 1'b0, rst = 1'b1, tso_en = 1'b0;
  logic [NL-1:0] ld_req = '0, ld_issue;
  logic [NS-1:0] st_req = '0, st_issue;
  logic cache_nack = 1'b0, cache_ready = 1'b0, st_done = 1'b0;
  logic ld_wake, cache_blocked, st_blocked, st_busy;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ls_port_limiter #(.NUM_LD(NL), .NUM_ST(NS), .LD_LIMIT(2), .ST_LIMIT(3)) u_ls_port_limiter (
    .clk(clk), .rst(rst), .tso_en(tso_en), .ld_req(ld_req), .st_req(st_req),
    .cache_nack(cache_nack), .cache_ready(cache_ready), .st_done(st_done),
    .ld_issue(ld_issue), .st_issue(st_issue), .ld_wake(ld_wake),
    .cache_blocked(cache_blocked), .st_blocked(st_blocked), .st_busy(st_busy));

  // {ld_req, st_req, exp ld_issue, exp st_issue, exp ld_wake after edge}
  localparam logic [16:0] VEC [8] = '{
    {4'b1111, 4'b1111, 4'b0011, 4'b0111, 1'b1},
    {4'b0001, 4'b0000, 4'b0001, 4'b0000, 1'b0},
    {4'b1010, 4'b1011, 4'b1010, 4'b1011, 1'b1},
    {4'b0100, 4'b1110, 4'b0100, 4'b1110, 1'b0},
    {4'b1000, 4'b0001, 4'b1000, 4'b0001, 1'b0},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0},
    {4'b1100, 4'b1101, 4'b1100, 4'b1101, 1'b1},
    {4'b0111, 4'b1111, 4'b0011, 4'b0111, 1'b1}
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] l, input logic [3:0] s, input logic t,
                       input logic nk, input logic rdy, input logic dn);
    @(negedge clk);
    ld_req = l; st_req = s; tso_en = t; cache_nack = nk; cache_ready = rdy; st_done = dn;
    #1;
  endtask

  task automatic edge_settle();
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 5000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 wake", {3'b0, ld_wake}, 4'b0);
    chk("R10 blocked", {3'b0, cache_blocked}, 4'b0);
    chk("R10 st_blocked/st_busy", {2'b0, st_blocked, st_busy}, 4'b0);
    @(negedge clk); rst = 1'b0;

    for (int k = 0; k < 8; k++) begin
      drive(VEC[k][16:13], VEC[k][12:9], 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R1 ld grants", ld_issue, VEC[k][8:5]);
      chk("R2/R6 st grants", st_issue, VEC[k][4:1]);
      edge_settle();
      chk("R5 wake", {3'b0, ld_wake}, {3'b0, VEC[k][0]});
    end

    // R8: st_busy is 1 here but tso off; grants unaffected
    drive(4'b0000, 4'b0110, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 busy", {3'b0, st_busy}, 4'b0001);
    chk("R8 st grants", st_issue, 4'b0110);
    edge_settle();

    // R3/R4/R9: full-budget issue rejected
    drive(4'b1111, 4'b0001, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R4 ld issued", ld_issue, 4'b0011);
    edge_settle();
    chk("R3 blocked set", {3'b0, cache_blocked}, 4'b0001);
    chk("R4 no wake", {3'b0, ld_wake}, 4'b0);
    chk("R9 st_blocked set", {3'b0, st_blocked}, 4'b0001);

    drive(4'b1111, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R3 no ld while blocked", ld_issue, 4'b0);
    chk("R3 no st while blocked", st_issue, 4'b0);
    edge_settle();
    chk("R3 stays blocked", {3'b0, cache_blocked}, 4'b0001);

    drive(4'b0000, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b1);
    edge_settle();
    chk("R3 ready clears", {3'b0, cache_blocked}, 4'b0);
    chk("R9 held", {3'b0, st_blocked}, 4'b0001);
    chk("R7 done clears busy", {3'b0, st_busy}, 4'b0);

    // R7: ordering gate
    drive(4'b0000, 4'b1111, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 single store", st_issue, 4'b0001);
    edge_settle();
    chk("R9 accept clears", {3'b0, st_blocked}, 4'b0);
    chk("R7 busy set", {3'b0, st_busy}, 4'b0001);

    drive(4'b0011, 4'b0110, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R7 held while busy", st_issue, 4'b0);
    chk("R6 loads unaffected", ld_issue, 4'b0011);
    edge_settle();
    chk("R5 wake after full", {3'b0, ld_wake}, 4'b0001);

    drive(4'b0000, 4'b0110, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R8 tso off ignores busy", st_issue, 4'b0110);
    edge_settle();

    // R10: reset mid-run
    @(negedge clk); rst = 1'b1; ld_req = '0; st_req = '0;
    edge_settle();
    chk("R10 busy cleared", {3'b0, st_busy}, 4'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule